// File: doc/BRIEF.md
# Multi-Lane Transmit Phase Alignment Sequencer

This controller runs a manual transmit phase and delay alignment procedure over four serial transceiver lanes. It runs entirely on a free-running management clock. A request from the master lane starts the sequence. The block then moves through four steps in turn: delay soft reset, phase-alignment initialization, phase alignment and delay enable. In each step it raises one strobe per lane and waits for that lane's matching completion indication.

Every completion input reaches the management clock through a two-flop synchronizer. Only the synchronized copies are used. The per-lane phase-align-done indication is edge-counted. Alignment of a lane counts as finished on the second rising edge seen after its delay soft reset completed. When all four lanes have finished, a single aligned flag goes high, and that flag feeds every lane.

A fresh request restarts the procedure at the delay soft-reset step. This holds whether the sequence is mid-run or already finished. If any step waits longer than the `WAIT_LIMIT` parameter allows, the procedure also restarts at the delay soft-reset step.

Top module: `txalign_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, all strobe outputs and `aligned_o` are low.
- R2: A rising edge of `start_req` that is first sampled at clock edge k makes `dlyrst_o` equal 4'hF after clock edge k+2. Bit i of every per-lane vector belongs to lane i, and each completion input passes through two synchronizing flops.
- R3: During the soft-reset and init steps, each lane's strobe (`dlyrst_o[i]`, then `phinit_o[i]`) stays high until that lane's synchronized done input (`dlyrst_done_i[i]`, then `phinit_done_i[i]`) is seen. It goes low on the next edge, and other lanes are not affected.
- R4: The steps run in the fixed order soft reset, init, align, delay enable. A step is left only when all four lanes have reported done. At most one strobe group is active at a time.
- R5: The count of rising edges of a lane's synchronized `phalign_done_i[i]` is cleared during the soft-reset step. `phalign_o[i]` drops after the first counted edge. `dlyen_o[i]` stays high until the second counted edge.
- R6: `aligned_o` goes high directly from the delay-enable step, once every lane has counted two edges. While it is high, no strobe is active, and it stays high until a restart.
- R7: A new rising edge of `start_req` during any step or after completion clears `aligned_o` and restarts at the soft-reset step, with all four `dlyrst_o` bits high.
- R8: If a step has not completed after `WAIT_LIMIT` cycles, the sequence restarts at the soft-reset step. With all lanes still pending, a strobe group therefore stays active for exactly `WAIT_LIMIT` cycles.
- R9: If the last lane of a step completes in the same cycle that the wait limit expires, the sequence advances instead of restarting.
- R10: Holding `start_req` high is not a new request: `aligned_o` stays high while the request level persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running management clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Alignment request from the master lane (edge-detected) |
| dlyrst_done_i | input | 4 | Per-lane delay soft-reset complete |
| phinit_done_i | input | 4 | Per-lane phase init complete |
| phalign_done_i | input | 4 | Per-lane phase-align done indication (edge-counted) |
| dlyrst_o | output | 4 | Per-lane delay soft-reset strobe |
| phinit_o | output | 4 | Per-lane phase init strobe |
| phalign_o | output | 4 | Per-lane phase-align strobe |
| dlyen_o | output | 4 | Per-lane manual delay-enable strobe |
| aligned_o | output | 1 | Alignment complete, fanned out to all lanes |

## Verification
Two things can fall in the same cycle: the wait limit expiring, and the slowest lane finishing the step. The bench provokes this by sweeping the init response delay of one lane across a window around the limit. One delay in that window lands its synchronized done exactly on the expiry cycle. The behavioural model flags that run, and on every clock it judges whether the design advanced to the align step instead of falling back to soft reset.

// File: rtl/txalign_pkg.sv
package txalign_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DLYRST = 3'd1,
        ST_PHINIT = 3'd2,
        ST_ALIGN  = 3'd3,
        ST_DLYEN  = 3'd4,
        ST_DONE   = 3'd5
    } step_e;

    // Raw and synchronized view of every asynchronous status input.
    typedef struct packed {
        logic             start;
        logic [LANES-1:0] rst_done;
        logic [LANES-1:0] init_done;
        logic [LANES-1:0] align_done;
    } stat_t;

    function automatic logic is_wait(step_e s);
        return (s == ST_DLYRST) || (s == ST_PHINIT) ||
               (s == ST_ALIGN)  || (s == ST_DLYEN);
    endfunction

    function automatic step_e step_after(step_e s);
        case (s)
            ST_DLYRST: return ST_PHINIT;
            ST_PHINIT: return ST_ALIGN;
            ST_ALIGN:  return ST_DLYEN;
            ST_DLYEN:  return ST_DONE;
            default:   return s;
        endcase
    endfunction

endpackage

// File: rtl/txalign_sync.sv
module txalign_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/txalign_lane.sv
module txalign_lane
    import txalign_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    input  logic  step_clr,
    input  logic  rst_done_s,
    input  logic  init_done_s,
    input  logic  align_done_s,
    output logic  dlyrst_o,
    output logic  phinit_o,
    output logic  phalign_o,
    output logic  dlyen_o,
    output logic  lane_ok
);
    logic       ack;
    logic       align_prev;
    logic       align_rise;
    logic [1:0] edges;

    assign align_rise = align_done_s & ~align_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack        <= 1'b0;
            align_prev <= 1'b0;
            edges      <= 2'd0;
        end else begin
            align_prev <= align_done_s;
            if (step_clr)
                ack <= 1'b0;
            else if ((step == ST_DLYRST && rst_done_s) ||
                     (step == ST_PHINIT && init_done_s))
                ack <= 1'b1;
            if (step == ST_IDLE || step == ST_DLYRST)
                edges <= 2'd0;
            else if (align_rise && edges != 2'd2)
                edges <= edges + 2'd1;
        end
    end

    assign dlyrst_o  = (step == ST_DLYRST) && !ack;
    assign phinit_o  = (step == ST_PHINIT) && !ack;
    assign phalign_o = (step == ST_ALIGN)  && (edges == 2'd0);
    assign dlyen_o   = (step == ST_DLYEN)  && (edges != 2'd2);

    always_comb begin
        case (step)
            ST_DLYRST, ST_PHINIT: lane_ok = ack;
            ST_ALIGN:             lane_ok = (edges != 2'd0);
            ST_DLYEN:             lane_ok = (edges == 2'd2);
            default:              lane_ok = 1'b0;
        endcase
    end

    // R3: a seen soft-reset done drops this lane's strobe on the next edge
    p_dlyrst_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (step == ST_DLYRST && rst_done_s && !step_clr) |=> !dlyrst_o);

    // R5: first counted align edge ends the phase-align strobe
    p_phalign_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ALIGN && align_rise && !step_clr) |=> !phalign_o);
endmodule

// File: rtl/txalign_ctrl.sv
module txalign_ctrl
    import txalign_pkg::*;
#(
    parameter int WAIT_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_s,
    input  logic [LANES-1:0] lane_ok,
    output step_e            step,
    output logic             step_clr
);
    localparam int TW = $clog2(WAIT_LIMIT + 1);

    logic          start_prev;
    logic          start_rise;
    logic          all_ok;
    logic          waiting;
    logic          expired;
    logic          restart;
    logic [TW-1:0] tmr;
    step_e         nxt;

    assign start_rise = start_s & ~start_prev;
    assign all_ok     = &lane_ok;
    assign waiting    = is_wait(step);
    assign expired    = waiting && (tmr == TW'(WAIT_LIMIT - 1)) && !all_ok;

    always_comb begin
        nxt     = step;
        restart = 1'b0;
        if (start_rise || expired) begin
            nxt     = ST_DLYRST;
            restart = 1'b1;
        end else if (waiting && all_ok) begin
            nxt = step_after(step);
        end
    end

    assign step_clr = restart || (nxt != step);

    always_ff @(posedge clk) begin
        if (rst) begin
            step       <= ST_IDLE;
            start_prev <= 1'b0;
            tmr        <= '0;
        end else begin
            step       <= nxt;
            start_prev <= start_s;
            if (step_clr || !waiting)
                tmr <= '0;
            else
                tmr <= tmr + TW'(1);
        end
    end

    // R7: a new request always lands in the soft-reset step
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        start_rise |=> (step == ST_DLYRST));

    // R4: an incomplete, unexpired step is held
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (waiting && !all_ok && !start_rise && !expired) |=> (step == $past(step)));
endmodule

// File: rtl/txalign_seq.sv
module txalign_seq
    import txalign_pkg::*;
#(
    parameter int WAIT_LIMIT  = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [LANES-1:0] dlyrst_done_i,
    input  logic [LANES-1:0] phinit_done_i,
    input  logic [LANES-1:0] phalign_done_i,
    output logic [LANES-1:0] dlyrst_o,
    output logic [LANES-1:0] phinit_o,
    output logic [LANES-1:0] phalign_o,
    output logic [LANES-1:0] dlyen_o,
    output logic             aligned_o
);
    stat_t            raw;
    stat_t            syn;
    step_e            step;
    logic             step_clr;
    logic [LANES-1:0] lane_ok;

    assign raw.start      = start_req;
    assign raw.rst_done   = dlyrst_done_i;
    assign raw.init_done  = phinit_done_i;
    assign raw.align_done = phalign_done_i;

    txalign_sync #(.WIDTH($bits(stat_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    txalign_ctrl #(.WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_s  (syn.start),
        .lane_ok  (lane_ok),
        .step     (step),
        .step_clr (step_clr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        txalign_lane u_lane (
            .clk          (clk),
            .rst          (rst),
            .step         (step),
            .step_clr     (step_clr),
            .rst_done_s   (syn.rst_done[g]),
            .init_done_s  (syn.init_done[g]),
            .align_done_s (syn.align_done[g]),
            .dlyrst_o     (dlyrst_o[g]),
            .phinit_o     (phinit_o[g]),
            .phalign_o    (phalign_o[g]),
            .dlyen_o      (dlyen_o[g]),
            .lane_ok      (lane_ok[g])
        );
    end

    assign aligned_o = (step == ST_DONE);

    // R4: strobe groups never overlap
    p_one_group_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|dlyrst_o, |phinit_o, |phalign_o, |dlyen_o}));

    // R6: completion is quiet
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        aligned_o |-> ((dlyrst_o | phinit_o | phalign_o | dlyen_o) == '0));

    // R6: completion is entered only from the delay-enable step
    p_done_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned_o) |-> ($past(step) == ST_DLYEN));
endmodule

// File: tb/tb_txalign_seq.sv
module tb_txalign_seq;
    localparam int LIM = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_req;
    logic [3:0] dlyrst_done_i = '0, phinit_done_i = '0, phalign_done_i = '0;
    logic [3:0] dlyrst_o, phinit_o, phalign_o, dlyen_o;
    logic       aligned_o;

    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    txalign_seq #(.WAIT_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .start_req(start_req),
        .dlyrst_done_i(dlyrst_done_i), .phinit_done_i(phinit_done_i),
        .phalign_done_i(phalign_done_i),
        .dlyrst_o(dlyrst_o), .phinit_o(phinit_o), .phalign_o(phalign_o),
        .dlyen_o(dlyen_o), .aligned_o(aligned_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- transceiver responder ----------------
    int lat_rd[4], lat_in[4], lat_al[4];
    int hr[4], hi[4], ca[4], cd[4];
    logic al[4];
    logic mute_in[4];
    initial for (int i = 0; i < 4; i++) begin
        hr[i] = 0; hi[i] = 0; ca[i] = 0; cd[i] = 0; al[i] = 0; mute_in[i] = 0;
        lat_rd[i] = 2 + i; lat_in[i] = 3; lat_al[i] = 2 + i;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (dlyrst_o[i]) hr[i]++; else hr[i] = 0;
            dlyrst_done_i[i] = (hr[i] > 0) && (hr[i] >= lat_rd[i]);
            if (phinit_o[i]) hi[i]++; else hi[i] = 0;
            phinit_done_i[i] = !mute_in[i] && (hi[i] > 0) && (hi[i] >= lat_in[i]);
            if (dlyrst_o[i]) begin ca[i] = 0; cd[i] = 0; al[i] = 0; end
            if (phalign_o[i]) begin ca[i]++; if (ca[i] >= lat_al[i]) al[i] = 1; end
            if (dlyen_o[i]) begin
                cd[i]++;
                if (cd[i] == lat_al[i]) al[i] = 0;
                if (cd[i] == lat_al[i] + 3) al[i] = 1;
            end else cd[i] = 0;
            phalign_done_i[i] = al[i];
        end
    end

    // ---------------- behavioural reference model ----------------
    // steps: 0 idle, 1 soft reset, 2 init, 3 align, 4 delay enable, 5 done
    int m_step, m_tmr;
    int m_ack[4], m_edges[4];
    logic [12:0] hist[$];
    bit coincide_seen = 0;

    always @(posedge clk) begin
        logic [12:0] s, p, cur;
        bit rise, wt, allok, exp_t, clr;
        int nstep;
        bit ok[4];
        cur = {start_req, dlyrst_done_i, phinit_done_i, phalign_done_i};
        if (rst) begin
            m_step = 0; m_tmr = 0;
            for (int i = 0; i < 4; i++) begin m_ack[i] = 0; m_edges[i] = 0; end
            hist = '{13'd0, 13'd0, 13'd0};
        end else begin
            s = hist[1]; p = hist[0];
            rise = s[12] && !p[12];
            allok = 1;
            for (int i = 0; i < 4; i++) begin
                case (m_step)
                    1, 2: ok[i] = (m_ack[i] != 0);
                    3:    ok[i] = (m_edges[i] >= 1);
                    4:    ok[i] = (m_edges[i] == 2);
                    default: ok[i] = 0;
                endcase
                allok = allok && ok[i];
            end
            wt = (m_step >= 1 && m_step <= 4);
            exp_t = wt && (m_tmr == LIM - 1) && !allok;
            if (wt && (m_tmr == LIM - 1) && allok && !rise) coincide_seen = 1;
            nstep = m_step;
            if (rise || exp_t) nstep = 1;
            else if (wt && allok) nstep = m_step + 1;
            clr = rise || exp_t || (nstep != m_step);
            for (int i = 0; i < 4; i++) begin
                if (clr) m_ack[i] = 0;
                else if ((m_step == 1 && s[8 + i]) || (m_step == 2 && s[4 + i])) m_ack[i] = 1;
                if (m_step <= 1) m_edges[i] = 0;
                else if (s[i] && !p[i] && m_edges[i] < 2) m_edges[i]++;
            end
            m_tmr = (clr || !wt) ? 0 : m_tmr + 1;
            m_step = nstep;
            hist.push_back(cur);
            void'(hist.pop_front());
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0] e_rd, e_in, e_pa, e_de;
        if (!rst) begin
            for (int i = 0; i < 4; i++) begin
                e_rd[i] = (m_step == 1) && (m_ack[i] == 0);
                e_in[i] = (m_step == 2) && (m_ack[i] == 0);
                e_pa[i] = (m_step == 3) && (m_edges[i] == 0);
                e_de[i] = (m_step == 4) && (m_edges[i] != 2);
            end
            chk("R3", "model dlyrst_o", dlyrst_o, e_rd);
            chk("R3", "model phinit_o", phinit_o, e_in);
            chk("R5", "model phalign_o", phalign_o, e_pa);
            chk("R5", "model dlyen_o", dlyen_o, e_de);
            chk("R6", "model aligned_o", aligned_o, m_step == 5);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_until_grp(input int grp, input logic [3:0] val, input int maxc,
                                  output bit hit);
        logic [3:0] v;
        hit = 0;
        for (int n = 0; n < maxc && !hit; n++) begin
            @(negedge clk);
            case (grp)
                0: v = dlyrst_o; 1: v = phinit_o; 2: v = phalign_o; 3: v = dlyen_o;
                default: v = {3'b0, aligned_o};
            endcase
            hit = (grp == 1) ? (v != 0) : (v == val);
        end
    endtask

    task automatic pulse_start();
        start_req = 1;
        repeat (2) @(negedge clk);
        start_req = 0;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        bit hit;
        int run;
        rst = 1; start_req = 0;
        repeat (5) @(negedge clk);
        chk("R1", "aligned_o in reset", aligned_o, 0);
        chk("R1", "strobes in reset", {dlyrst_o, phinit_o, phalign_o, dlyen_o}, 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "strobes after reset", {dlyrst_o, phinit_o, phalign_o, dlyen_o, aligned_o}, 0);

        // R2: request latency, slow lane 3 for R3
        lat_rd[3] = 20;
        start_req = 1;
        @(negedge clk); chk("R2", "dlyrst_o after edge k", dlyrst_o, 4'h0);
        @(negedge clk); chk("R2", "dlyrst_o after edge k+1", dlyrst_o, 4'h0);
        @(negedge clk); chk("R2", "dlyrst_o after edge k+2", dlyrst_o, 4'hF);
        wait_until_grp(0, 4'b1000, 60, hit);
        chk("R3", "only slow lane 3 still in soft reset", hit, 1);
        wait_until_grp(4, 4'h1, 600, hit);
        chk("R6", "aligned after full sequence", hit, 1);
        chk("R6", "strobes quiet when aligned", {dlyrst_o, phinit_o, phalign_o, dlyen_o}, 0);
        lat_rd[3] = 3;

        // R10: held request does not retrigger
        repeat (20) @(negedge clk);
        chk("R10", "aligned held with level request", aligned_o, 1);

        // R7: restart after completion
        start_req = 0;
        repeat (5) @(negedge clk);
        start_req = 1;
        repeat (2) @(negedge clk);
        chk("R7", "aligned before restart edge", aligned_o, 1);
        @(negedge clk);
        chk("R7", "aligned cleared on restart", aligned_o, 0);
        chk("R7", "soft reset restarted", dlyrst_o, 4'hF);
        start_req = 0;

        // R7: restart mid-run during init
        wait_until_grp(1, 4'h0, 200, hit);
        chk("R4", "init step reached after soft reset", hit, 1);
        start_req = 1;
        repeat (3) @(negedge clk);
        chk("R7", "mid-run restart dlyrst_o", dlyrst_o, 4'hF);
        chk("R7", "mid-run restart phinit_o", phinit_o, 4'h0);
        start_req = 0;
        wait_until_grp(4, 4'h1, 600, hit);
        chk("R4", "completes after mid-run restart", hit, 1);

        // R8: lane 2 never finishes init
        mute_in[2] = 1;
        pulse_start();
        wait_until_grp(1, 4'h0, 200, hit);
        run = 0;
        while (phinit_o != 0 && run < 4 * LIM) begin run++; @(negedge clk); end
        chk("R8", "init strobe run length", run, LIM);
        chk("R8", "restart to soft reset on timeout", dlyrst_o, 4'hF);
        mute_in[2] = 0;
        wait_until_grp(4, 4'h1, 1000, hit);
        chk("R8", "recovers after timeout", hit, 1);

        // R9: sweep lane 2 init delay across the limit
        for (int lat = LIM - 8; lat <= LIM + 2; lat++) begin
            lat_in[2] = lat;
            pulse_start();
            repeat (3 * LIM) @(negedge clk);
        end
        chk("R9", "completion coincided with expiry", coincide_seen, 1);
        lat_in[2] = 3;
        pulse_start();
        wait_until_grp(4, 4'h1, 600, hit);
        chk("R6", "aligned after sweep", hit, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule